// File: doc/BRIEF.md
# Edge-Driven Event Counter Channel

This block is one channel of a timer array operated as an event counter. A one-cycle start strobe turns the channel on and copies a reload value into the count register. From then on the register steps down by one for every qualifying transition on an external event line. The event line is asynchronous to the module clock. It passes through a synchroniser and, when chosen at run time, through a noise filter that accepts a new level only after it has been seen on two consecutive clock samples.

When a qualifying transition arrives while the count is already zero, the channel emits a one-clock interrupt pulse and reloads from the reload value, then keeps counting. A stop strobe turns the channel off and freezes the count. A later start reloads it. The edge that qualifies is picked by a two-bit select: rising, falling or both.

Top module: `evt_count_chan`

## Requirements
- R1: After reset, count_o is all ones, enable_o is 0 and irq_o is 0.
- R2: While enable_o is 0 and no start strobe is present, count_o keeps its value and transitions on evt_i have no effect on it.
- R3: A start strobe sets enable_o to 1 and loads reload_i into count_o at the next clock edge. When start and stop arrive in the same cycle, start wins.
- R4: While enabled, count_o decreases by exactly one for each qualifying transition on evt_i when its value is not zero.
- R5: edge_sel_i picks the qualifying transition: 2'b00 rising only, 2'b01 falling only, 2'b10 or 2'b11 both directions.
- R6: A qualifying transition seen while count_o is 0 raises irq_o for exactly one cycle and puts reload_i into count_o. Counting then goes on from that value.
- R7: A stop strobe (without start) clears enable_o at the next clock edge, and count_o then holds its value. A later start reloads from reload_i.
- R8: With the filter off, a level change applied to evt_i between two clock edges shows on count_o after the third following rising clock edge.
- R9: With filt_en_i high, the same change shows on count_o after the fifth rising clock edge, two cycles later than without the filter. A pulse that spans only one clock sample is rejected and does not count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start strobe |
| stop_i | input | 1 | One-cycle stop strobe |
| reload_i | input | W | Reload value loaded on start and on expiry |
| edge_sel_i | input | 2 | Qualifying transition select (00 rise, 01 fall, 1x both) |
| filt_en_i | input | 1 | Enables the two-sample noise filter |
| evt_i | input | 1 | Asynchronous external event line |
| count_o | output | W | Current count register value |
| enable_o | output | 1 | Channel running flag |
| irq_o | output | 1 | One-cycle pulse on count expiry |

## Verification
The bench builds the channel with a 4-bit count, a two-flop synchroniser and a filter hold of two samples. At that width every reload value from 0 to 15 can be swept against every edge select with the filter on and off. Each combination runs a string of transitions long enough to wrap the counter several times. This brings reload-at-zero, repeated interrupts and the all-ones reset value within reach. Exact clock-by-clock latency and one-sample glitch rejection are measured at the same small configuration.

// File: rtl/evc_pkg.sv
package evc_pkg;

   typedef enum logic [1:0] {
      SEL_RISE = 2'b00,
      SEL_FALL = 2'b01,
      SEL_BOTH = 2'b10,
      SEL_ANY  = 2'b11
   } edge_sel_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MIN_HOLD        = 2;

endpackage

// File: rtl/evc_sync.sv
module evc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   import evc_pkg::*;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("evc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/evc_filter.sv
module evc_filter #(
   parameter int unsigned HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic lvl_o
);
   import evc_pkg::*;

   if (HOLD < MIN_HOLD) begin : g_bad_hold
      $error("evc_filter: HOLD must be at least 2");
   end

   logic [HOLD-2:0] hist;
   logic [HOLD-1:0] window;
   logic            flt;
   logic            agree;

   assign window = {hist, din};
   assign agree  = (&window) | ~(|window);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         flt  <= 1'b0;
      end else begin
         hist <= window[HOLD-2:0];
         if (agree) flt <= din;
      end
   end

   assign lvl_o = en ? flt : din;

   // R9
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flt != $past(flt)) |-> ($past(window) == {HOLD{flt}}));

endmodule

// File: rtl/evc_edge.sv
module evc_edge (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic [1:0] sel,
   output logic       edge_o
);
   import evc_pkg::*;

   logic      prev;
   logic      rise;
   logic      fall;
   edge_sel_e mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
   assign mode = edge_sel_e'(sel);

   always_comb begin
      unique case (mode)
         SEL_RISE: edge_o = rise;
         SEL_FALL: edge_o = fall;
         default:  edge_o = rise | fall;
      endcase
   end

   // R5
   edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rise, fall}));

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         stop,
   input  logic         evt_edge,
   input  logic [W-1:0] reload,
   output logic [W-1:0] count,
   output logic         enable,
   output logic         irq
);

   localparam logic [W-1:0] INIT_VAL = '1;
   localparam logic [W-1:0] ZERO_VAL = '0;
   localparam logic [W-1:0] ONE_VAL  = W'(1);

   logic expire;
   logic step;

   assign step   = enable & ~start & ~stop & evt_edge;
   assign expire = step & (count == ZERO_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= INIT_VAL;
         enable <= 1'b0;
         irq    <= 1'b0;
      end else begin
         irq <= expire;
         if (start) begin
            enable <= 1'b1;
            count  <= reload;
         end else if (stop) begin
            enable <= 1'b0;
         end else if (expire) begin
            count <= reload;
         end else if (step) begin
            count <= count - ONE_VAL;
         end
      end
   end

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !start) |=> $stable(count));

   // R3
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (enable && count == $past(reload)));

   // R4
   dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !start && !stop && evt_edge && count != ZERO_VAL)
      |=> (count == $past(count) - ONE_VAL));

   // R6
   irq_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (count == $past(reload) && $past(count) == ZERO_VAL));

   // R7
   stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> (!enable && count == $past(count)));

endmodule

// File: rtl/evt_count_chan.sv
module evt_count_chan #(
   parameter int unsigned W           = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_HOLD   = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic         stop_i,
   input  logic [W-1:0] reload_i,
   input  logic [1:0]   edge_sel_i,
   input  logic         filt_en_i,
   input  logic         evt_i,
   output logic [W-1:0] count_o,
   output logic         enable_o,
   output logic         irq_o
);

   if (W < 2) begin : g_bad_width
      $error("evt_count_chan: W must be at least 2");
   end

   logic sync_lvl;
   logic clean_lvl;
   logic evt_edge;

   evc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (evt_i),
      .dout (sync_lvl)
   );

   evc_filter #(.HOLD(FILT_HOLD)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (filt_en_i),
      .din  (sync_lvl),
      .lvl_o(clean_lvl)
   );

   evc_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (clean_lvl),
      .sel   (edge_sel_i),
      .edge_o(evt_edge)
   );

   evc_counter #(.W(W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .stop    (stop_i),
      .evt_edge(evt_edge),
      .reload  (reload_i),
      .count   (count_o),
      .enable  (enable_o),
      .irq     (irq_o)
   );

   // R6
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && reload_i != '0) |=> !irq_o);

endmodule

// File: tb/tb_evt_count_chan.sv
module tb_evt_count_chan;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         stop_i = 1'b0;
   logic [W-1:0] reload_i = '0;
   logic [1:0]   edge_sel_i = 2'b00;
   logic         filt_en_i = 1'b0;
   logic         evt_i = 1'b0;
   logic [W-1:0] count_o;
   logic         enable_o;
   logic         irq_o;

   int checks = 0;
   int errors = 0;
   int irq_seen = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   evt_count_chan #(.W(W), .SYNC_STAGES(2), .FILT_HOLD(2)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
      .reload_i(reload_i), .edge_sel_i(edge_sel_i), .filt_en_i(filt_en_i),
      .evt_i(evt_i), .count_o(count_o), .enable_o(enable_o), .irq_o(irq_o)
   );

   always @(negedge clk) if (rst_n && irq_o) irq_seen++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start(input int val);
      reload_i = W'(val);
      start_i  = 1'b1;
      step(1);
      start_i  = 1'b0;
   endtask

   task automatic do_stop();
      stop_i = 1'b1;
      step(1);
      stop_i = 1'b0;
   endtask

   function automatic bit qualifies(input int sel, input bit rising);
      if (sel == 0) return rising;
      if (sel == 1) return !rising;
      return 1'b1;
   endfunction

   initial begin
      step(200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int exp_cnt;
      int exp_irq;
      int held;
      int lat;
      step(3);
      rst_n = 1'b1;
      step(2);

      // R1 reset state
      check(count_o == 4'hF, "R1 count", count_o, 15);
      check(enable_o == 1'b0, "R1 enable", enable_o, 0);
      check(irq_o == 1'b0, "R1 irq", irq_o, 0);

      // R2 edges while stopped are ignored
      for (int k = 0; k < 4; k++) begin
         evt_i = ~evt_i;
         step(7);
      end
      check(count_o == 4'hF, "R2 idle hold", count_o, 15);

      // R3 start loads, start beats stop
      reload_i = 4'd6;
      start_i = 1'b1;
      stop_i  = 1'b1;
      step(1);
      start_i = 1'b0;
      stop_i  = 1'b0;
      check(enable_o == 1'b1, "R3 start over stop enable", enable_o, 1);
      check(count_o == 4'd6, "R3 load", count_o, 6);

      // R8 latency without filter, rising edge
      edge_sel_i = 2'b00;
      filt_en_i  = 1'b0;
      evt_i = 1'b0;
      step(8);
      held = count_o;
      evt_i = 1'b1;
      lat = 0;
      for (int i = 1; i <= 8; i++) begin
         step(1);
         if (lat == 0 && count_o != W'(held)) lat = i;
      end
      check(lat == 3, "R8 latency", lat, 3);

      // R9 latency with filter
      evt_i = 1'b0;
      filt_en_i = 1'b1;
      step(8);
      held = count_o;
      evt_i = 1'b1;
      lat = 0;
      for (int i = 1; i <= 8; i++) begin
         step(1);
         if (lat == 0 && count_o != W'(held)) lat = i;
      end
      check(lat == 5, "R9 latency", lat, 5);

      // R9 one-sample glitch rejected with filter on
      evt_i = 1'b0;
      step(8);
      held = count_o;
      evt_i = 1'b1;
      step(1);
      evt_i = 1'b0;
      step(8);
      check(count_o == W'(held), "R9 glitch reject", count_o, held);

      // R8 same glitch counted with filter off
      filt_en_i = 1'b0;
      step(4);
      held = count_o;
      evt_i = 1'b1;
      step(1);
      evt_i = 1'b0;
      step(8);
      check(count_o == W'(held - 1), "R8 short pulse counted", count_o, held - 1);

      // R4 R5 R6 sweep: filter, edge select, every reload value
      for (int f = 0; f < 2; f++) begin
         for (int sel = 0; sel < 4; sel++) begin
            for (int rv = 0; rv < 16; rv++) begin
               do_stop();
               evt_i = 1'b0;
               filt_en_i = f[0];
               edge_sel_i = 2'(sel);
               step(8);
               do_start(rv);
               irq_seen = 0;
               exp_cnt = rv;
               exp_irq = 0;
               for (int k = 1; k <= 14; k++) begin
                  evt_i = ~evt_i;
                  step(7);
                  if (qualifies(sel, (k % 2) == 1)) begin
                     if (exp_cnt == 0) begin
                        exp_cnt = rv;
                        exp_irq++;
                     end else begin
                        exp_cnt--;
                     end
                  end
               end
               check(count_o == W'(exp_cnt), "R4 R5 count sweep", count_o, exp_cnt);
               check(irq_seen == exp_irq, "R6 irq sweep", irq_seen, exp_irq);
            end
         end
      end

      // R6 irq lasts exactly one cycle
      do_stop();
      evt_i = 1'b0;
      filt_en_i = 1'b0;
      edge_sel_i = 2'b10;
      step(8);
      do_start(0);
      evt_i = 1'b1;
      step(2);
      check(irq_o == 1'b0, "R6 irq before expiry", irq_o, 0);
      step(1);
      check(irq_o == 1'b1, "R6 irq pulse", irq_o, 1);
      step(1);
      check(irq_o == 1'b0, "R6 irq one cycle", irq_o, 0);

      // R7 stop holds count and ignores edges, restart reloads
      do_start(9);
      evt_i = 1'b0;
      step(7);
      check(count_o == 4'd8, "R7 pre-stop count", count_o, 8);
      do_stop();
      check(enable_o == 1'b0, "R7 stop clears enable", enable_o, 0);
      for (int k = 0; k < 3; k++) begin
         evt_i = ~evt_i;
         step(7);
      end
      check(count_o == 4'd8, "R7 held after stop", count_o, 8);
      do_start(11);
      check(count_o == 4'd11 && enable_o, "R7 restart reload", count_o, 11);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule